// File: doc/BRIEF.md
# Serial Mode-Register Port

This block is a four-wire serial slave that gives a host read and write access to a small bank of 8-bit mode registers. Each access is one 16-bit word, sent most significant bit first while chip select is held low. The first bit selects a read (1) or a write (0). The next seven bits give a register index. The last eight bits carry the write data on the input line, or the read data on the output line.

The register bank is inside the block. Six writable registers sit at indices 16 to 21, and their contents drive dedicated configuration outputs. Index 22 is read-only and returns two zero-detect flags. Index 23 is read-only and returns a five-bit device identifier. Both come from input pins. Bit 6 of register 20 is a write-only request: writing 1 to it gives a single one-cycle pulse on a dedicated output, and the bit always reads back as 0.

The serial pins are brought into the system clock domain through synchronizers, and the bit-clock edges are detected from the synchronized copy. The serial bit clock must therefore run well below the system clock. The bench uses a ratio of 12 to 1.

Top module: `spi_regport`

## Requirements
- R1: After reset, the configuration outputs hold these values: index 16 = 0xFF, 17 = 0xFF, 18 = 0x50, 19 = 0x00, 20 = 0x00, 21 = 0x01.
- R2: A write word is bit 15 = 0, bits 14..8 = index, bits 7..0 = data. It updates the indexed register (16..21) once the 16th rising bit-clock edge of the frame has been sampled, and not before.
- R3: For a read word (bit 15 = 1), the data output presents the addressed register MSB first. Bit 7 appears after the falling edge that follows the 8th rising edge, and each later falling edge advances one bit. The data output is low at every other time, including whenever chip select is high.
- R4: A frame in which chip select rises before the 16th rising bit-clock edge writes nothing.
- R5: After 16 bits, further bit-clock edges are ignored until chip select returns high. No second word is started within the same low period of chip select.
- R6: Writes to index 22, index 23, or any index outside 16..23 change nothing. Reads of indices outside 16..23 return 0x00.
- R7: Index 22 reads as {6'b0, zero_flag_r, zero_flag_l}. Index 23 reads as {3'b0, chain_id}. Both reflect the inputs at the time of the read.
- R8: Writing a 1 to bit 6 of index 20 produces exactly one `soft_reset_pulse` lasting one clock cycle. That bit is never stored and reads as 0.
- R9: Each configuration output equals the current content of its register: att_left = 16, att_right = 17, mode_a = 18, mode_b = 19, mode_c = 20, mode_d = 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial bit clock |
| spi_mosi | input | 1 | Serial data in, sampled on rising bit-clock edges |
| spi_miso | output | 1 | Serial data out, changes after falling bit-clock edges |
| zero_flag_l | input | 1 | Left zero-detect status, read at index 22 bit 0 |
| zero_flag_r | input | 1 | Right zero-detect status, read at index 22 bit 1 |
| chain_id | input | 5 | Device identifier, read at index 23 |
| att_left | output | 8 | Register 16 contents |
| att_right | output | 8 | Register 17 contents |
| mode_a | output | 8 | Register 18 contents |
| mode_b | output | 8 | Register 19 contents |
| mode_c | output | 8 | Register 20 contents (bit 6 always 0) |
| mode_d | output | 8 | Register 21 contents |
| soft_reset_pulse | output | 1 | One-cycle pulse on a write of 1 to index 20 bit 6 |

## Verification
A bit counter that slips by one shifts the latched index and data. The wrong register then changes, or the right register takes a value rotated by one bit, on the configuration outputs about three system clocks after the 16th rising edge. A counter that fails to stop at 16, or that fails to clear when chip select rises, shows up on the next frame as a missed or early commit. A wrong read-path state shows up within one serial bit time as a mismatched or mistimed bit on the data output. The bench compares every configuration output against its own model on every clock while no frame is in flight. It also checks every data-output bit of every frame.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int WORD_W    = 16;
    localparam int IDX_W     = 7;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int FIRST_RW  = 16;
    localparam int NUM_RW    = 6;
    localparam int STATUS_IX = 22;
    localparam int ID_IX     = 23;
    localparam int RST_REQ_IX  = 20;
    localparam int RST_REQ_BIT = 6;
    localparam int ID_W      = 5;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    function automatic byte_t reset_value(input int slot);
        case (slot)
            0, 1:    return 8'hFF;
            2:       return 8'h50;
            5:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic mosi_s
);
    // bit 2 = sclk, bit 1 = cs_n, bit 0 = mosi
    typedef struct packed {
        logic [STAGES-1:0][2:0] chain;
        logic                   sclk_prev;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = {sclk_raw, cs_n_raw, mosi_raw};
        for (int s = 1; s < STAGES; s++) begin
            state_d.chain[s] = state_q.chain[s-1];
        end
        state_d.sclk_prev = state_q.chain[STAGES-1][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                state_q.chain[s] <= 3'b010;
            end
            state_q.sclk_prev <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sclk_rise = state_q.chain[STAGES-1][2] & ~state_q.sclk_prev;
    assign sclk_fall = ~state_q.chain[STAGES-1][2] & state_q.sclk_prev;
    assign cs_n_s    = state_q.chain[STAGES-1][1];
    assign mosi_s    = state_q.chain[STAGES-1][0];

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regport_pkg::*;
#(
    parameter int WORD_BITS = WORD_W,
    parameter int IDX_BITS  = IDX_W,
    parameter int DAT_BITS  = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                cs_n_i,
    input  logic                mosi_i,
    input  logic [DAT_BITS-1:0] rd_data_i,
    output logic [IDX_BITS-1:0] idx_o,
    output logic                wr_en_o,
    output logic [DAT_BITS-1:0] wr_data_o,
    output logic                miso_o
);
    localparam int CW       = $clog2(WORD_BITS + 1);
    localparam int SH_W     = WORD_BITS - 1;
    localparam logic [CW-1:0] LAST    = CW'(WORD_BITS);
    localparam logic [CW-1:0] HDR_END = CW'(WORD_BITS - DAT_BITS);

    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic [SH_W-1:0]     sh;
        logic                is_rd;
        logic [IDX_BITS-1:0] idx;
        logic                wr_en;
        logic [DAT_BITS-1:0] wr_data;
        logic                drive;
        logic [DAT_BITS-1:0] tx;
    } frame_state_t;

    frame_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.wr_en = 1'b0;
        if (cs_n_i) begin
            state_d.cnt   = '0;
            state_d.is_rd = 1'b0;
            state_d.drive = 1'b0;
            state_d.tx    = '0;
        end else begin
            if (rise_i && state_q.cnt < LAST) begin
                state_d.sh  = {state_q.sh[SH_W-2:0], mosi_i};
                state_d.cnt = state_q.cnt + 1'b1;
                if (state_q.cnt == '0) begin
                    state_d.is_rd = mosi_i;
                end
                if (state_q.cnt == HDR_END - 1'b1) begin
                    state_d.idx = {state_q.sh[IDX_BITS-2:0], mosi_i};
                end
                if (state_q.cnt == LAST - 1'b1) begin
                    state_d.wr_en   = ~state_q.is_rd;
                    state_d.wr_data = {state_q.sh[DAT_BITS-2:0], mosi_i};
                end
            end
            if (fall_i) begin
                if (state_q.cnt == HDR_END && state_q.is_rd && !state_q.drive) begin
                    state_d.drive = 1'b1;
                    state_d.tx    = rd_data_i;
                end else if (state_q.drive && state_q.cnt < LAST) begin
                    state_d.tx = {state_q.tx[DAT_BITS-2:0], 1'b0};
                end else if (state_q.cnt == LAST) begin
                    state_d.drive = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign idx_o     = state_q.idx;
    assign wr_en_o   = state_q.wr_en;
    assign wr_data_o = state_q.wr_data;
    assign miso_o    = state_q.drive & state_q.tx[DAT_BITS-1];

    // R2: a commit only ever follows a complete word
    a_r2_commit_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> state_q.cnt == LAST);
    // R5: the bit counter never passes the word length
    a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= LAST);
    a_r5_hold_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == LAST && !cs_n_i) |=> state_q.cnt == LAST);
    // R4: raising chip select always clears the frame
    a_r4_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (state_q.cnt == '0 && !wr_en_o));
    // R3: the data output is quiet once chip select is high
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !miso_o);

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int IDX_BITS = IDX_W,
    parameter int DAT_BITS = DATA_W,
    parameter int N_RW     = NUM_RW,
    parameter int BASE     = FIRST_RW
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_BITS-1:0]            idx_i,
    input  logic                           wr_en_i,
    input  logic [DAT_BITS-1:0]            wr_data_i,
    input  logic [1:0]                     zero_i,
    input  logic [ID_W-1:0]                id_i,
    output logic [DAT_BITS-1:0]            rd_data_o,
    output logic [N_RW-1:0][DAT_BITS-1:0]  regs_o,
    output logic                           pulse_o
);
    localparam int REQ_SLOT = RST_REQ_IX - BASE;

    typedef struct packed {
        logic [N_RW-1:0][DAT_BITS-1:0] regs;
        logic                          pulse;
    } bank_state_t;

    bank_state_t state_d, state_q;
    logic [N_RW-1:0] hit;

    generate
        for (genvar g = 0; g < N_RW; g++) begin : g_decode
            assign hit[g] = (idx_i == IDX_BITS'(BASE + g));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        state_d.pulse = 1'b0;
        if (wr_en_i) begin
            for (int k = 0; k < N_RW; k++) begin
                if (hit[k]) begin
                    state_d.regs[k] = wr_data_i;
                end
            end
            if (hit[REQ_SLOT]) begin
                state_d.pulse = wr_data_i[RST_REQ_BIT];
                state_d.regs[REQ_SLOT][RST_REQ_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_RW; k++) begin
                state_q.regs[k] <= reset_value(k);
            end
            state_q.pulse <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < N_RW; k++) begin
            if (hit[k]) begin
                rd_data_o = state_q.regs[k];
            end
        end
        if (idx_i == IDX_BITS'(STATUS_IX)) begin
            rd_data_o = {{(DAT_BITS-2){1'b0}}, zero_i};
        end
        if (idx_i == IDX_BITS'(ID_IX)) begin
            rd_data_o = {{(DAT_BITS-ID_W){1'b0}}, id_i};
        end
    end

    assign regs_o  = state_q.regs;
    assign pulse_o = state_q.pulse;

    // R6: writes outside the writable window leave the bank untouched
    a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit == '0) |=> $stable(state_q.regs));
    // R8: the request pulse lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R8: the request bit is never held
    a_r8_bit_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.regs[REQ_SLOT][RST_REQ_BIT]);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic        zero_flag_l,
    input  logic        zero_flag_r,
    input  logic [4:0]  chain_id,
    output logic [7:0]  att_left,
    output logic [7:0]  att_right,
    output logic [7:0]  mode_a,
    output logic [7:0]  mode_b,
    output logic [7:0]  mode_c,
    output logic [7:0]  mode_d,
    output logic        soft_reset_pulse
);
    logic rise, fall, cs_n_s, mosi_s;
    idx_t  idx;
    logic  wr_en;
    byte_t wr_data, rd_data;
    logic [NUM_RW-1:0][DATA_W-1:0] regs;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_raw  (spi_sclk),
        .cs_n_raw  (spi_cs_n),
        .mosi_raw  (spi_mosi),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s)
    );

    spi_frame_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .cs_n_i    (cs_n_s),
        .mosi_i    (mosi_s),
        .rd_data_i (rd_data),
        .idx_o     (idx),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .miso_o    (spi_miso)
    );

    spi_reg_bank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (idx),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .zero_i    ({zero_flag_r, zero_flag_l}),
        .id_i      (chain_id),
        .rd_data_o (rd_data),
        .regs_o    (regs),
        .pulse_o   (soft_reset_pulse)
    );

    assign att_left  = regs[0];
    assign att_right = regs[1];
    assign mode_a    = regs[2];
    assign mode_b    = regs[3];
    assign mode_c    = regs[4];
    assign mode_d    = regs[5];

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso;
    logic zl = 1'b0, zr = 1'b0;
    logic [4:0] cid = 5'd0;
    logic [7:0] o_al, o_ar, o_ma, o_mb, o_mc, o_md;
    logic pulse;

    int vectors = 0, errors = 0;
    int pulses = 0, wide = 0, exp_pulses = 0;
    bit busy = 1'b1;
    bit finished = 1'b0;
    logic prev_pulse = 1'b0;
    logic [7:0] model [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport i_spi_regport (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .zero_flag_l(zl), .zero_flag_r(zr), .chain_id(cid),
        .att_left(o_al), .att_right(o_ar), .mode_a(o_ma), .mode_b(o_mb),
        .mode_c(o_mc), .mode_d(o_md), .soft_reset_pulse(pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] expect_read(input logic [6:0] ix);
        if (ix >= 7'd16 && ix <= 7'd21) return model[ix];
        if (ix == 7'd22) return {6'b0, zr, zl};
        if (ix == 7'd23) return {3'b0, cid};
        return 8'h00;
    endfunction

    // R9 / R2: outputs follow the model on every clock while idle
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            chk(o_al == model[16], "R9 att_left", o_al, model[16]);
            chk(o_ar == model[17], "R9 att_right", o_ar, model[17]);
            chk(o_ma == model[18], "R9 mode_a", o_ma, model[18]);
            chk(o_mb == model[19], "R9 mode_b", o_mb, model[19]);
            chk(o_mc == model[20], "R9 mode_c", o_mc, model[20]);
            chk(o_md == model[21], "R9 mode_d", o_md, model[21]);
            chk(miso == 1'b0, "R3 idle miso", miso, 0);
        end
    end

    always @(posedge clk) begin
        if (pulse) pulses++;
        if (pulse && prev_pulse) wide++;
        prev_pulse <= pulse;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, input int extra, input string req);
        logic [7:0] rd_exp;
        busy = 1'b1;
        rd_exp = expect_read(w[14:8]);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int b = 0; b < nbits; b++) begin
            mosi = w[15-b];
            wait_clk(HALF_BIT);
            if (w[15] && b >= 8)
                chk(miso == rd_exp[15-b], {req, " R3 read bit"}, miso, rd_exp[15-b]);
            else
                chk(miso == 1'b0, {req, " R3 quiet bit"}, miso, 0);
            sclk = 1'b1;
            wait_clk(HALF_BIT);
            sclk = 1'b0;
        end
        for (int e = 0; e < extra; e++) begin
            mosi = 1'b1;
            wait_clk(HALF_BIT);
            chk(miso == 1'b0, {req, " R5 quiet after word"}, miso, 0);
            sclk = 1'b1;
            wait_clk(HALF_BIT);
            sclk = 1'b0;
        end
        wait_clk(HALF_BIT);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(8);
        if (nbits == 16 && !w[15] && w[14:8] >= 7'd16 && w[14:8] <= 7'd21) begin
            model[w[14:8]] = w[7:0];
            if (w[14:8] == 7'd20) begin
                model[20][6] = 1'b0;
                if (w[6]) exp_pulses++;
            end
        end
        busy = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model[16] = 8'hFF; model[17] = 8'hFF; model[18] = 8'h50; model[21] = 8'h01;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset values
        chk(o_al == 8'hFF, "R1 reg16", o_al, 8'hFF);
        chk(o_ar == 8'hFF, "R1 reg17", o_ar, 8'hFF);
        chk(o_ma == 8'h50, "R1 reg18", o_ma, 8'h50);
        chk(o_mb == 8'h00, "R1 reg19", o_mb, 0);
        chk(o_mc == 8'h00, "R1 reg20", o_mc, 0);
        chk(o_md == 8'h01, "R1 reg21", o_md, 1);
        chk(pulse == 1'b0, "R8 no pulse at reset", pulse, 0);
        busy = 1'b0;
        wait_clk(4);
        // R3: read every defined register in reset state
        for (int ix = 16; ix <= 23; ix++) xfer({1'b1, 7'(ix), 8'h00}, 16, 0, "R1");
        // R2: writes with several patterns
        xfer({1'b0, 7'd16, 8'hA5}, 16, 0, "R2");
        xfer({1'b0, 7'd17, 8'h0E}, 16, 0, "R2");
        xfer({1'b0, 7'd18, 8'h3C}, 16, 0, "R2");
        xfer({1'b0, 7'd19, 8'hFF}, 16, 0, "R2");
        xfer({1'b0, 7'd21, 8'h80}, 16, 0, "R2");
        xfer({1'b0, 7'd20, 8'hBF}, 16, 0, "R2");
        for (int ix = 16; ix <= 21; ix++) xfer({1'b1, 7'(ix), 8'h5A}, 16, 0, "R3");
        // R8: request bit
        xfer({1'b0, 7'd20, 8'h40}, 16, 0, "R8");
        xfer({1'b1, 7'd20, 8'h00}, 16, 0, "R8");
        xfer({1'b0, 7'd20, 8'hFF}, 16, 0, "R8");
        xfer({1'b1, 7'd20, 8'h00}, 16, 0, "R8");
        chk(pulses == exp_pulses, "R8 pulse count", pulses, exp_pulses);
        chk(wide == 0, "R8 pulse width", wide, 0);
        // R4: aborted frames
        xfer({1'b0, 7'd16, 8'h11}, 10, 0, "R4");
        xfer({1'b0, 7'd17, 8'h22}, 15, 0, "R4");
        xfer({1'b0, 7'd18, 8'h33}, 8, 0, "R4");
        xfer({1'b1, 7'd16, 8'h00}, 16, 0, "R4");
        // R5: extra clocks after the word
        xfer({1'b0, 7'd19, 8'h12}, 16, 17, "R5");
        xfer({1'b1, 7'd19, 8'h00}, 16, 0, "R5");
        xfer({1'b1, 7'd21, 8'h00}, 16, 9, "R5");
        // R6: ignored writes and undefined reads
        xfer({1'b0, 7'd22, 8'hFF}, 16, 0, "R6");
        xfer({1'b0, 7'd23, 8'hFF}, 16, 0, "R6");
        xfer({1'b0, 7'd5,  8'h77}, 16, 0, "R6");
        xfer({1'b0, 7'd100, 8'h77}, 16, 0, "R6");
        xfer({1'b0, 7'd24, 8'h77}, 16, 0, "R6");
        xfer({1'b1, 7'd5,  8'h00}, 16, 0, "R6");
        xfer({1'b1, 7'd127, 8'h00}, 16, 0, "R6");
        xfer({1'b1, 7'd0,  8'h00}, 16, 0, "R6");
        // R7: status inputs
        zl = 1'b1; cid = 5'h15;
        xfer({1'b1, 7'd22, 8'h00}, 16, 0, "R7");
        xfer({1'b1, 7'd23, 8'h00}, 16, 0, "R7");
        zl = 1'b0; zr = 1'b1; cid = 5'h0A;
        xfer({1'b1, 7'd22, 8'h00}, 16, 0, "R7");
        xfer({1'b1, 7'd23, 8'h00}, 16, 0, "R7");
        zl = 1'b1; cid = 5'h1F;
        xfer({1'b1, 7'd22, 8'h00}, 16, 0, "R7");
        xfer({1'b1, 7'd23, 8'h00}, 16, 0, "R7");
        wait_clk(10);
        chk(pulses == exp_pulses, "R8 final pulse count", pulses, exp_pulses);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule